// File: doc/BRIEF.md
# Serial NAND Bad-Block Remap Engine

This block runs the bad-block remap table that lives inside a serial NAND device. It reaches the device through a single-lane SPI master that it drives itself, with the byte shifter included. A host sends it one of three commands over a request/acknowledge port. A dump command reads the whole on-device table into local storage, where each entry is kept as a logical word and a physical word. An add command writes one new remap pair to the device. An allocate command picks the reserved block to use as the next replacement.

Before an add, the engine reads the device status register and refuses the entry if the device says its table is full. After it sends the entry, it polls the busy bit until the bit clears or a timeout expires. An allocate first refreshes the local table with a dump. It then finds the highest physical block already in use and offers the candidate blocks after it, one at a time, to an outside judge that answers good or bad. The first good block is the result. Replacement blocks come from a reserved pool at the top of the array.

Top module: `bbt_engine`

## Requirements
- R1: A dump request produces one chip-select window of exactly 2 + 4*ENTRIES bytes: opcode 0xA5, one dummy byte (8 clocks), then the table bytes. The request is acknowledged without error.
- R2: Dumped entry k is read from bytes 2+4k .. 5+4k in this order: physical high, physical low, logical high, logical low. It appears on `tblPhysical`/`tblLogical` when `tblIdx` equals k.
- R3: An add request first reads status in one window: opcode 0x05, address 0xC0, then one data byte. If bit 6 of that byte is set, the engine acknowledges with `reqErr` and sends no 0xA1 transaction.
- R4: When the table is not full, an add sends one window of five bytes: 0xA1, logical high, logical low, physical high, physical low. All values are taken from the request.
- R5: After the add window, the engine repeats the status read until bit 0 (busy) reads 0, then acknowledges without error. If bit 0 is still 1 after TIMEOUT_CYCLES cycles of polling, it acknowledges with `reqErr`.
- R6: An allocate runs a dump first. An entry counts as in use only when bit 15 of its logical word is 1 and bit 14 is 0; entries with bits 15:14 = 00 are empty and do not count. Candidates are offered in ascending order, starting at the larger of (highest in-use physical block + 1) and the pool start NUM_BLOCKS-POOL_SIZE. When no entry is in use, the start is the pool start.
- R7: The first candidate answered good is returned on `allocBlock`, with `reqAck` high and `reqErr` low.
- R8: If no good candidate is found up to block NUM_BLOCKS-1, `exhausted` rises and stays high until reset, and the request is acknowledged with an error. Later allocate requests are acknowledged with an error, with no SPI window and no candidate query.
- R9: The SPI runs in mode 0: `spiSclk` is low whenever `spiCsN` is high, and bytes go out most-significant bit first.
- R10: After reset, `spiCsN`=1, `spiSclk`=0, `reqReady`=1, `reqAck`=0, `exhausted`=0, and every stored table word is zero.
- R11: A request is taken only while `reqReady` is high. `reqValid` asserted while the engine is busy has no effect. `reqAck` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 2 | 0 dump, 1 add, 2 allocate, 3 rejected |
| reqLogical | input | 16 | Logical word for add |
| reqPhysical | input | 16 | Physical word for add |
| reqReady | output | 1 | Engine idle, request accepted |
| reqAck | output | 1 | Completion pulse |
| reqErr | output | 1 | Error qualifier, valid with reqAck |
| allocBlock | output | BLK_W (10) | Chosen replacement block |
| exhausted | output | 1 | Sticky pool-exhausted flag |
| candValid | output | 1 | Candidate offered for judgement |
| candBlock | output | BLK_W (10) | Candidate block number |
| candResp | input | 1 | Judgement present |
| candGood | input | 1 | Judgement: block is good |
| tblIdx | input | IDX_W (5) | Stored entry select |
| tblLogical | output | 16 | Stored logical word |
| tblPhysical | output | 16 | Stored physical word |
| spiSclk | output | 1 | SPI clock |
| spiCsN | output | 1 | SPI chip select, active low |
| spiMosi | output | 1 | SPI data out |
| spiMiso | input | 1 | SPI data in |

## Verification
A wrong byte counter or entry slice puts the wrong words in the table. It also shifts the start of the candidate sweep, and that shows at the very next allocate as a wrong first `candBlock`. A bad status-bit decode shows within one add: an 0xA1 window goes out when it should not, or the acknowledge comes too early or too late compared with the number of busy polls. A lost sticky flag shows on the next allocate, when a new SPI window or query appears where none should.

// File: rtl/bbt_pkg.sv
package bbt_pkg;
  localparam logic [7:0] OPC_LUT_READ = 8'hA5;
  localparam logic [7:0] OPC_LUT_ADD  = 8'hA1;
  localparam logic [7:0] OPC_STAT_RD  = 8'h05;
  localparam logic [7:0] ADR_STATUS   = 8'hC0;

  localparam logic [1:0] OP_DUMP  = 2'd0;
  localparam logic [1:0] OP_ADD   = 2'd1;
  localparam logic [1:0] OP_ALLOC = 2'd2;

  typedef enum logic [1:0] {PH_DUMP, PH_STAT, PH_ADD} phase_t;

  typedef enum logic [2:0] {
    S_IDLE, S_XSTART, S_XWAIT, S_CSOFF, S_SINIT, S_ASK, S_NEXT, S_ACK
  } state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       csOn;
    logic       start;
    logic [7:0] txByte;
    logic       tblLoad;
    logic [7:0] tblOff;
  } bbt_strobe_t;
endpackage

// File: rtl/bbt_datapath.sv
module bbt_datapath
  import bbt_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int ENTRIES  = 20,
  parameter int IDX_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  bbt_strobe_t       ctl,
  input  logic              spiMiso,
  output logic              spiSclk,
  output logic              spiCsN,
  output logic              spiMosi,
  output logic              shDone,
  output logic [7:0]        rxByte,
  output logic              anyEnabled,
  output logic [15:0]       maxPhys,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [15:0]       rdLogical,
  output logic [15:0]       rdPhysical
);
  localparam int HC_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [HC_W-1:0] halfCnt;
  logic [2:0]      bitCnt;
  logic            shBusy;
  logic [7:0]      txSh, rxSh;
  logic            sclkR, doneR, csNR;

  // byte shifter, mode 0: sample on rise, shift on fall
  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfCnt <= '0; bitCnt <= '0; shBusy <= 1'b0;
      txSh <= '0; rxSh <= '0; sclkR <= 1'b0; doneR <= 1'b0; csNR <= 1'b1;
    end else begin
      doneR <= 1'b0;
      csNR  <= !ctl.csOn;
      if (ctl.start) begin
        shBusy <= 1'b1; txSh <= ctl.txByte; halfCnt <= '0; bitCnt <= '0; sclkR <= 1'b0;
      end else if (shBusy) begin
        if (halfCnt == HC_W'(HALF_DIV - 1)) begin
          halfCnt <= '0;
          if (!sclkR) begin
            sclkR <= 1'b1;
            rxSh  <= {rxSh[6:0], spiMiso};
          end else begin
            sclkR  <= 1'b0;
            txSh   <= {txSh[6:0], 1'b0};
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              shBusy <= 1'b0;
              doneR  <= 1'b1;
            end
          end
        end else begin
          halfCnt <= halfCnt + HC_W'(1);
        end
      end
    end
  end

  assign spiSclk = sclkR;
  assign spiCsN  = csNR;
  assign spiMosi = txSh[7];
  assign shDone  = doneR;
  assign rxByte  = rxSh;

  // table storage, one slot per entry
  logic [15:0] logW  [ENTRIES];
  logic [15:0] physW [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        logW[g]  <= '0;
        physW[g] <= '0;
      end else if (ctl.tblLoad && ctl.tblOff[7:2] == 6'(g)) begin
        case (ctl.tblOff[1:0])
          2'd0: physW[g][15:8] <= rxSh;
          2'd1: physW[g][7:0]  <= rxSh;
          2'd2: logW[g][15:8]  <= rxSh;
          default: logW[g][7:0] <= rxSh;
        endcase
      end
    end
  end

  always_comb begin
    rdLogical  = '0;
    rdPhysical = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rdIdx == IDX_W'(i)) begin
        rdLogical  = logW[i];
        rdPhysical = physW[i];
      end
    end
  end

  // highest physical block among in-use entries
  always_comb begin
    anyEnabled = 1'b0;
    maxPhys    = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (logW[i][15] && !logW[i][14]) begin
        if (!anyEnabled || physW[i] > maxPhys) maxPhys = physW[i];
        anyEnabled = 1'b1;
      end
    end
  end

  p_sclk_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSclk);
  p_start_when_free_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.start |-> !shBusy);
endmodule

// File: rtl/bbt_ctrl.sv
module bbt_ctrl
  import bbt_pkg::*;
#(
  parameter int NUM_BLOCKS     = 1024,
  parameter int POOL_SIZE      = 20,
  parameter int ENTRIES        = 20,
  parameter int TIMEOUT_CYCLES = 500000,
  parameter int BLK_W          = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [15:0]      reqLogical,
  input  logic [15:0]      reqPhysical,
  output logic             reqReady,
  output logic             reqAck,
  output logic             reqErr,
  output logic [BLK_W-1:0] allocBlock,
  output logic             exhausted,
  output logic             candValid,
  output logic [BLK_W-1:0] candBlock,
  input  logic             candResp,
  input  logic             candGood,
  output bbt_strobe_t      ctl,
  input  logic             shDone,
  input  logic [7:0]       rxByte,
  input  logic             anyEnabled,
  input  logic [15:0]      maxPhys
);
  localparam int POOL_START = NUM_BLOCKS - POOL_SIZE;
  localparam int DUMP_LEN   = 2 + 4 * ENTRIES;
  localparam int TMO_W      = $clog2(TIMEOUT_CYCLES + 1);

  state_t            state;
  phase_t            phase;
  logic [1:0]        opR;
  logic [15:0]       lbaR, pbaR, cand;
  logic [7:0]        byteIdx, lastIdx, statR, txB;
  logic              pollR, errR, exhR;
  logic [TMO_W-1:0]  tmo;
  logic [BLK_W-1:0]  allocR;
  logic [16:0]       startBlk;

  always_comb begin
    txB = 8'h00;
    case (phase)
      PH_DUMP: begin
        lastIdx = 8'(DUMP_LEN - 1);
        if (byteIdx == 8'd0) txB = OPC_LUT_READ;
      end
      PH_STAT: begin
        lastIdx = 8'd2;
        if (byteIdx == 8'd0) txB = OPC_STAT_RD;
        else if (byteIdx == 8'd1) txB = ADR_STATUS;
      end
      default: begin
        lastIdx = 8'd4;
        case (byteIdx)
          8'd0: txB = OPC_LUT_ADD;
          8'd1: txB = lbaR[15:8];
          8'd2: txB = lbaR[7:0];
          8'd3: txB = pbaR[15:8];
          default: txB = pbaR[7:0];
        endcase
      end
    endcase
  end

  always_comb begin
    startBlk = anyEnabled ? ({1'b0, maxPhys} + 17'd1) : 17'(POOL_START);
    if (startBlk < 17'(POOL_START)) startBlk = 17'(POOL_START);
  end

  assign ctl.csOn    = (state == S_XSTART) || (state == S_XWAIT);
  assign ctl.start   = (state == S_XSTART);
  assign ctl.txByte  = txB;
  assign ctl.tblLoad = (state == S_XWAIT) && shDone && (phase == PH_DUMP) && (byteIdx >= 8'd2);
  assign ctl.tblOff  = byteIdx - 8'd2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; phase <= PH_DUMP; opR <= OP_DUMP;
      lbaR <= '0; pbaR <= '0; cand <= '0; byteIdx <= '0; statR <= '0;
      pollR <= 1'b0; errR <= 1'b0; exhR <= 1'b0; tmo <= '0; allocR <= '0;
    end else begin
      if (pollR && tmo != TMO_W'(TIMEOUT_CYCLES)) tmo <= tmo + TMO_W'(1);
      case (state)
        S_IDLE: if (reqValid) begin
          opR <= reqOp; lbaR <= reqLogical; pbaR <= reqPhysical;
          byteIdx <= '0; pollR <= 1'b0; errR <= 1'b0;
          if (reqOp == OP_DUMP) begin
            phase <= PH_DUMP; state <= S_XSTART;
          end else if (reqOp == OP_ADD) begin
            phase <= PH_STAT; state <= S_XSTART;
          end else if (reqOp == OP_ALLOC && !exhR) begin
            phase <= PH_DUMP; state <= S_XSTART;
          end else begin
            errR <= 1'b1; state <= S_ACK;
          end
        end
        S_XSTART: state <= S_XWAIT;
        S_XWAIT: if (shDone) begin
          if (phase == PH_STAT && byteIdx == 8'd2) statR <= rxByte;
          if (byteIdx == lastIdx) state <= S_CSOFF;
          else begin
            byteIdx <= byteIdx + 8'd1;
            state   <= S_XSTART;
          end
        end
        S_CSOFF: begin
          byteIdx <= '0;
          case (phase)
            PH_DUMP: state <= (opR == OP_ALLOC) ? S_SINIT : S_ACK;
            PH_ADD: begin
              phase <= PH_STAT; pollR <= 1'b1; tmo <= '0; state <= S_XSTART;
            end
            default: begin
              if (!pollR) begin
                if (statR[6]) begin
                  errR <= 1'b1; state <= S_ACK;
                end else begin
                  phase <= PH_ADD; state <= S_XSTART;
                end
              end else if (!statR[0]) begin
                pollR <= 1'b0; state <= S_ACK;
              end else if (tmo == TMO_W'(TIMEOUT_CYCLES)) begin
                pollR <= 1'b0; errR <= 1'b1; state <= S_ACK;
              end else begin
                state <= S_XSTART;
              end
            end
          endcase
        end
        S_SINIT: begin
          if (startBlk >= 17'(NUM_BLOCKS)) begin
            exhR <= 1'b1; errR <= 1'b1; state <= S_ACK;
          end else begin
            cand <= startBlk[15:0]; state <= S_ASK;
          end
        end
        S_ASK: if (candResp) begin
          if (candGood) begin
            allocR <= cand[BLK_W-1:0]; state <= S_ACK;
          end else if (cand == 16'(NUM_BLOCKS - 1)) begin
            exhR <= 1'b1; errR <= 1'b1; state <= S_ACK;
          end else begin
            cand <= cand + 16'd1; state <= S_NEXT;
          end
        end
        S_NEXT: state <= S_ASK;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign reqReady   = (state == S_IDLE);
  assign reqAck     = (state == S_ACK);
  assign reqErr     = (state == S_ACK) && errR;
  assign candValid  = (state == S_ASK);
  assign candBlock  = cand[BLK_W-1:0];
  assign allocBlock = allocR;
  assign exhausted  = exhR;

  p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);
  p_exhaust_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    exhausted |=> exhausted);
  p_no_query_exhausted_r8: assert property (@(posedge clk) disable iff (!rstN)
    exhausted |-> !candValid);
  p_cand_in_pool_r6: assert property (@(posedge clk) disable iff (!rstN)
    candValid |-> int'(candBlock) >= POOL_START);
  p_alloc_in_pool_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqAck && !reqErr && opR == OP_ALLOC) |-> int'(allocBlock) >= POOL_START);
  p_full_refused_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CSOFF && phase == PH_STAT && !pollR && statR[6]) |=> (reqAck && reqErr));
endmodule

// File: rtl/bbt_engine.sv
module bbt_engine
  import bbt_pkg::*;
#(
  parameter int NUM_BLOCKS     = 1024,
  parameter int POOL_SIZE      = 20,
  parameter int ENTRIES        = 20,
  parameter int HALF_DIV       = 4,
  parameter int TIMEOUT_CYCLES = 500000,
  localparam int BLK_W         = $clog2(NUM_BLOCKS),
  localparam int IDX_W         = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [15:0]      reqLogical,
  input  logic [15:0]      reqPhysical,
  output logic             reqReady,
  output logic             reqAck,
  output logic             reqErr,
  output logic [BLK_W-1:0] allocBlock,
  output logic             exhausted,
  output logic             candValid,
  output logic [BLK_W-1:0] candBlock,
  input  logic             candResp,
  input  logic             candGood,
  input  logic [IDX_W-1:0] tblIdx,
  output logic [15:0]      tblLogical,
  output logic [15:0]      tblPhysical,
  output logic             spiSclk,
  output logic             spiCsN,
  output logic             spiMosi,
  input  logic             spiMiso
);
  bbt_strobe_t ctl;
  logic        shDone, anyEnabled;
  logic [7:0]  rxByte;
  logic [15:0] maxPhys;

  bbt_ctrl #(
    .NUM_BLOCKS(NUM_BLOCKS), .POOL_SIZE(POOL_SIZE), .ENTRIES(ENTRIES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .BLK_W(BLK_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqLogical(reqLogical), .reqPhysical(reqPhysical), .reqReady(reqReady),
    .reqAck(reqAck), .reqErr(reqErr), .allocBlock(allocBlock), .exhausted(exhausted),
    .candValid(candValid), .candBlock(candBlock), .candResp(candResp), .candGood(candGood),
    .ctl(ctl), .shDone(shDone), .rxByte(rxByte), .anyEnabled(anyEnabled), .maxPhys(maxPhys)
  );

  bbt_datapath #(
    .HALF_DIV(HALF_DIV), .ENTRIES(ENTRIES), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .spiMiso(spiMiso), .spiSclk(spiSclk),
    .spiCsN(spiCsN), .spiMosi(spiMosi), .shDone(shDone), .rxByte(rxByte),
    .anyEnabled(anyEnabled), .maxPhys(maxPhys), .rdIdx(tblIdx),
    .rdLogical(tblLogical), .rdPhysical(tblPhysical)
  );
endmodule

// File: tb/tb_bbt_engine.sv
module tb_bbt_engine;
  localparam int NB = 1024, PS = 20, NE = 20, HD = 1, TMO = 4000;
  localparam int BW = 10, IW = 5, PSTART = NB - PS;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, reqValid, reqReady, reqAck, reqErr, exhausted, candValid, candResp, candGood;
  logic [1:0] reqOp;
  logic [15:0] reqLogical, reqPhysical, tblLogical, tblPhysical;
  logic [BW-1:0] allocBlock, candBlock;
  logic [IW-1:0] tblIdx;
  logic spiSclk, spiCsN, spiMosi, spiMiso;

  bbt_engine #(.NUM_BLOCKS(NB), .POOL_SIZE(PS), .ENTRIES(NE), .HALF_DIV(HD),
               .TIMEOUT_CYCLES(TMO)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqLogical(reqLogical),
    .reqPhysical(reqPhysical), .reqReady(reqReady), .reqAck(reqAck), .reqErr(reqErr),
    .allocBlock(allocBlock), .exhausted(exhausted), .candValid(candValid),
    .candBlock(candBlock), .candResp(candResp), .candGood(candGood), .tblIdx(tblIdx),
    .tblLogical(tblLogical), .tblPhysical(tblPhysical), .spiSclk(spiSclk),
    .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  int nChk = 0, nFail = 0;
  task automatic chkEq(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [15:0] mLog [NE];
  logic [15:0] mPhys [NE];
  bit forceFull = 0, stuckBusy = 0;
  int busyPolls = 0, busyLeft = 0;
  int bitIdx = 0, byteIdx = 0;
  logic [7:0] shiftIn = 0, curResp = 0;
  logic [7:0] rxb [128];
  int txnCount = 0, dumpTxn = 0, statTxn = 0, addTxn = 0, lastLen = 0, modeErr = 0;
  logic [7:0] lastAdd [5];
  logic [7:0] firstDumpByte = 0;

  function automatic bit modelFull();
    if (forceFull) return 1;
    for (int i = 0; i < NE; i++) if (mLog[i][15:14] == 2'b00) return 0;
    return 1;
  endfunction

  function automatic logic [7:0] respByte(int n);
    int e, k;
    if (rxb[0] == 8'hA5 && n >= 2 && n < 2 + 4 * NE) begin
      e = (n - 2) / 4; k = (n - 2) % 4;
      case (k)
        0: return mPhys[e][15:8];
        1: return mPhys[e][7:0];
        2: return mLog[e][15:8];
        default: return mLog[e][7:0];
      endcase
    end
    if (rxb[0] == 8'h05 && n == 2)
      return {1'b0, modelFull(), 5'b0, (busyLeft > 0 || stuckBusy)};
    return 8'h00;
  endfunction

  always @(negedge spiCsN) begin
    bitIdx = 0; byteIdx = 0; curResp = 8'h00; rxb[0] = 8'h00;
  end

  always @(posedge spiSclk) if (!spiCsN) begin
    shiftIn = {shiftIn[6:0], spiMosi};
    bitIdx++;
    if (bitIdx == 8) begin
      if (byteIdx < 128) rxb[byteIdx] = shiftIn;
      byteIdx++;
      bitIdx = 0;
      curResp = respByte(byteIdx);
    end
  end

  assign spiMiso = curResp[3'(7 - bitIdx)];

  always @(posedge spiCsN) if (byteIdx > 0) begin
    txnCount++;
    lastLen = byteIdx;
    if (rxb[0] == 8'hA5) begin
      dumpTxn++; firstDumpByte = rxb[0];
    end else if (rxb[0] == 8'h05) begin
      statTxn++;
      if (busyLeft > 0) busyLeft--;
    end else if (rxb[0] == 8'hA1 && byteIdx == 5) begin
      addTxn++;
      for (int i = 0; i < 5; i++) lastAdd[i] = rxb[i];
      begin : store
        for (int i = 0; i < NE; i++) if (mLog[i][15:14] == 2'b00) begin
          mLog[i] = {rxb[1], rxb[2]} | 16'h8000;
          mPhys[i] = {rxb[3], rxb[4]};
          disable store;
        end
      end
      busyLeft = busyPolls;
    end
    byteIdx = 0;
  end

  always @(posedge clk) if (rstN === 1'b1 && spiCsN === 1'b1 && spiSclk === 1'b1) modeErr++;

  // ---------------- candidate judge ----------------
  bit badMap [NB];
  int qCount = 0, qFirst = -1, qLast = -1;
  initial begin
    candResp = 0; candGood = 0;
    forever begin
      @(negedge clk);
      if (candValid && !candResp) begin
        candResp = 1;
        candGood = !badMap[candBlock];
        qCount++;
        if (qCount == 1) qFirst = int'(candBlock);
        qLast = int'(candBlock);
      end else begin
        candResp = 0;
      end
    end
  end

  // ---------------- expected-value helpers ----------------
  function automatic int expStart();
    int m = -1, s;
    for (int i = 0; i < NE; i++)
      if (mLog[i][15] && !mLog[i][14] && int'(mPhys[i]) > m) m = int'(mPhys[i]);
    s = (m < 0) ? PSTART : m + 1;
    if (s < PSTART) s = PSTART;
    return s;
  endfunction

  function automatic int expPick(int s);
    for (int b = s; b < NB; b++) if (!badMap[b]) return b;
    return -1;
  endfunction

  bit rErr; int rBlk; bit rTo;
  task automatic doReq(input logic [1:0] op, input logic [15:0] l, input logic [15:0] p);
    int n = 0;
    qCount = 0; qFirst = -1; qLast = -1;
    @(negedge clk);
    reqOp = op; reqLogical = l; reqPhysical = p; reqValid = 1;
    @(negedge clk);
    reqValid = 0;
    while (!reqAck && n < 20000) begin
      @(negedge clk); n++;
    end
    rTo = !reqAck;
    rErr = reqErr;
    rBlk = int'(allocBlock);
    if (rTo) begin
      nFail++; $display("FAIL R11 no acknowledge actual=0 expected=1");
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    int t0, s0, a0, d0, st, pk;
    rstN = 0; reqValid = 0; reqOp = 0; reqLogical = 0; reqPhysical = 0; tblIdx = 0;
    for (int i = 0; i < NE; i++) begin mLog[i] = 0; mPhys[i] = 0; end
    for (int b = 0; b < NB; b++) badMap[b] = 0;
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R10 reset state
    chkEq("R10 csN", int'(spiCsN), 1);
    chkEq("R10 sclk", int'(spiSclk), 0);
    chkEq("R10 ready", int'(reqReady), 1);
    chkEq("R10 ack", int'(reqAck), 0);
    chkEq("R10 exhausted", int'(exhausted), 0);
    for (int i = 0; i < NE; i += 19) begin
      tblIdx = IW'(i); #1;
      chkEq("R10 table logical zero", int'(tblLogical), 0);
      chkEq("R10 table physical zero", int'(tblPhysical), 0);
    end

    // device table preset: three in use, one invalid, rest empty
    mLog[0] = 16'h8005; mPhys[0] = 16'd1004;
    mLog[1] = 16'h8011; mPhys[1] = 16'd1006;
    mLog[2] = 16'h8020; mPhys[2] = 16'd1005;
    mLog[3] = 16'hC007; mPhys[3] = 16'd1010;
    mLog[7] = 16'h0000; mPhys[7] = 16'h1234; // empty slot with junk physical

    // R1/R2 dump
    t0 = txnCount;
    doReq(2'd0, 0, 0);
    chkEq("R1 dump no error", int'(rErr), 0);
    chkEq("R1 one window", txnCount - t0, 1);
    chkEq("R1 window length", lastLen, 2 + 4 * NE);
    chkEq("R1 opcode", int'(firstDumpByte), 8'hA5);
    for (int i = 0; i < NE; i++) begin
      tblIdx = IW'(i); #1;
      chkEq($sformatf("R2 entry %0d logical", i), int'(tblLogical), int'(mLog[i]));
      chkEq($sformatf("R2 entry %0d physical", i), int'(tblPhysical), int'(mPhys[i]));
    end

    // R11 request while busy is ignored
    t0 = txnCount; s0 = statTxn; a0 = addTxn; d0 = dumpTxn;
    @(negedge clk);
    reqOp = 2'd0; reqValid = 1;
    @(negedge clk);
    reqOp = 2'd1;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (c == 10) chkEq("R11 ready low while busy", int'(reqReady), 0);
    end
    reqValid = 0;
    while (!reqAck) @(negedge clk);
    @(negedge clk); @(negedge clk);
    chkEq("R11 single window", txnCount - t0, 1);
    chkEq("R11 no status read", statTxn - s0, 0);
    chkEq("R11 dump count", dumpTxn - d0, 1);

    // R6/R7 allocate skipping bad blocks
    badMap[1007] = 1; badMap[1008] = 1;
    st = expStart(); pk = expPick(st);
    doReq(2'd2, 0, 0);
    chkEq("R6 first candidate", qFirst, st);
    chkEq("R6 query count", qCount, pk - st + 1);
    chkEq("R7 alloc block", rBlk, pk);
    chkEq("R7 alloc no error", int'(rErr), 0);

    // R4/R5 add with busy polling
    busyPolls = 3; t0 = txnCount; s0 = statTxn; a0 = addTxn;
    doReq(2'd1, 16'h0033, 16'd1009);
    chkEq("R5 add no error", int'(rErr), 0);
    chkEq("R4 one add window", addTxn - a0, 1);
    chkEq("R4 byte0", int'(lastAdd[0]), 8'hA1);
    chkEq("R4 byte1", int'(lastAdd[1]), 8'h00);
    chkEq("R4 byte2", int'(lastAdd[2]), 8'h33);
    chkEq("R4 byte3", int'(lastAdd[3]), 8'h03);
    chkEq("R4 byte4", int'(lastAdd[4]), 8'hF1);
    chkEq("R5 status reads", statTxn - s0, 1 + busyPolls + 1);

    // R6 allocate after add follows the new highest block
    st = expStart(); pk = expPick(st);
    doReq(2'd2, 0, 0);
    chkEq("R6 start after add", qFirst, st);
    chkEq("R7 alloc after add", rBlk, pk);

    // R3 table full refusal
    forceFull = 1; t0 = txnCount; a0 = addTxn; s0 = statTxn;
    doReq(2'd1, 16'h0040, 16'd1011);
    chkEq("R3 full error", int'(rErr), 1);
    chkEq("R3 no add window", addTxn - a0, 0);
    chkEq("R3 one status window", statTxn - s0, 1);
    forceFull = 0;

    // R5 busy timeout
    stuckBusy = 1; busyPolls = 0;
    doReq(2'd1, 16'h0044, 16'd1010);
    chkEq("R5 timeout error", int'(rErr), 1);
    stuckBusy = 0;

    // R8 exhaustion
    for (int b = 1011; b < NB; b++) badMap[b] = 1;
    st = expStart();
    doReq(2'd2, 0, 0);
    chkEq("R8 first candidate", qFirst, st);
    chkEq("R8 query count", qCount, NB - st);
    chkEq("R8 error", int'(rErr), 1);
    chkEq("R8 exhausted set", int'(exhausted), 1);
    t0 = txnCount;
    doReq(2'd2, 0, 0);
    chkEq("R8 later alloc error", int'(rErr), 1);
    chkEq("R8 later alloc no window", txnCount - t0, 0);
    chkEq("R8 later alloc no query", qCount, 0);
    chkEq("R8 still exhausted", int'(exhausted), 1);
    chkEq("R9 mode 0 clock idle", modeErr, 0);

    // R10/R6 reset clears exhaustion; empty table starts at pool base
    @(negedge clk); rstN = 0;
    repeat (3) @(negedge clk); rstN = 1;
    @(negedge clk);
    chkEq("R10 exhausted cleared", int'(exhausted), 0);
    for (int i = 0; i < NE; i++) begin mLog[i] = 0; mPhys[i] = 0; end
    for (int b = 0; b < NB; b++) badMap[b] = 0;
    badMap[PSTART] = 1;
    doReq(2'd2, 0, 0);
    chkEq("R6 empty table start", qFirst, PSTART);
    chkEq("R7 empty table pick", rBlk, PSTART + 1);
    chkEq("R7 empty table no error", int'(rErr), 0);

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule